// File: doc/BRIEF.md
# Sleep Sequencing and Power-Off Controller

This block decides when a small processor system sleeps and how it wakes up. Software writes a control word that holds a sleep-enable bit, a 3-bit sleep-mode code and a watchdog-run bit. Software also writes a peripheral clock mask and a wake-up stabilisation delay. When the CPU raises a one-cycle sleep request, the controller moves to one of three states: idle, power-save or power-off. In idle and power-save it waits for a wake-up level that is held long enough. From power-save it then holds the CPU clock off for a programmable number of cycles before it resumes.

Power-off is the deepest state. It is armed only when the sleep request follows the control-word write within a short window. In power-off the regulator-off output is driven and every clock stops. The charger-detect input is the only way out. Leaving power-off always raises a system reset request; it never resumes.

The peripheral mask stops the clock of each masked peripheral. While a peripheral is masked, the block also discards writes to it and returns zero on reads from it. The state code appears on `pwrState`: 0 active, 1 idle, 2 power-save, 3 power-off, 4 stabilising, 5 reset request.

Top module: `pwrSleepCtl`

## Requirements
- R1: Configuration writes use `cfgAddr`. Address 0 is the control word: bit 0 sleep-enable, bits 3:1 mode code, bit 4 watchdog-run. Address 1 is the peripheral mask. Address 2 is the stabilisation delay. A `sleepReq` from active with sleep-enable set and mode 000 moves `pwrState` to 1 (idle), and with mode 011 moves it to 2 (power-save).
- R2: Mode 100 with sleep-enable set moves `pwrState` to 3 (power-off) only if the request is sampled 1 to 4 clock edges after the edge that took the control-word write. A request 5 or more edges later leaves the block active.
- R3: In power-off, `regOff` is 1, `cpuClkEn` is 0 and all peripheral clocks are 0. `wakeLvl` has no effect there; only `chargerDet` leads out.
- R4: `chargerDet` high in power-off gives one cycle with `pwrState` 5 and `sysRstReq` 1. The block then returns to active with the control word and the peripheral mask cleared.
- R5: `wdRunEn` follows the watchdog-run bit in every state except power-off, where it is 0.
- R6: A wake-up in power-save with a stabilisation delay D > 0 gives state 4, with the CPU clock off, for exactly D cycles before active. With D = 0 the block goes straight to active.
- R7: In idle or power-save, `wakeLvl` must be high for HOLD_CYC consecutive cycles to wake the block. A shorter pulse is ignored. Idle wakes straight to active.
- R8: When mask bit i is set, `periphClkEn[i]` is 0 in active and idle, writes to peripheral i are not forwarded on `perWrEn`, and reads from it return 0. Unmasked peripherals pass both reads and writes.
- R9: Clearing a mask bit restores that peripheral's clock and read data. No write reached the peripheral while it was masked.
- R10: In power-save, stabilising and power-off, every peripheral clock enable is 0.
- R11: A `sleepReq` with sleep-enable clear, or with a mode code other than 000, 011 or 100, is ignored and the block stays active.
- R12: After reset the block is active with `cpuClkEn` 1, `regOff` 0, `sysRstReq` 0, `wdRunEn` 0 and all peripheral clocks enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 2 | Configuration register select |
| cfgWdata | input | DLY_W | Configuration write data |
| sleepReq | input | 1 | One-cycle sleep request from the CPU |
| wakeLvl | input | 1 | Level wake-up source |
| chargerDet | input | 1 | Charger detected (power-off exit) |
| perSel | input | SEL_W | Peripheral addressed by the CPU |
| perWr | input | 1 | Peripheral write request |
| perRdIn | input | NUM_PERIPH*PER_DW | Read data from all peripherals, flattened |
| perRdOut | output | PER_DW | Gated read data to the CPU |
| perWrEn | output | NUM_PERIPH | Forwarded write strobe per peripheral |
| periphClkEn | output | NUM_PERIPH | Clock enable per peripheral |
| cpuClkEn | output | 1 | CPU clock enable |
| regOff | output | 1 | Regulator shut-down request |
| sysRstReq | output | 1 | System reset request |
| wdRunEn | output | 1 | Watchdog run enable |
| pwrState | output | 3 | Current state code |

## Verification
The bench builds the block with four peripherals of 8 bits and a 16-bit delay. It lowers the wake hold time to 3 cycles, so that both a 2-cycle pulse and a valid 3-cycle hold fit in a short directed test. The power-off window keeps its default of 4. This lets the bench probe the edge between request gaps of 4 and 5 cycles directly. A stabilisation delay of 5 is small enough to count state 4 cycle by cycle, and a delay of 0 tests the immediate path.

// File: rtl/pwrCtlPkg.sv
package pwrCtlPkg;

  typedef enum logic [2:0] {
    PS_ACTIVE = 3'd0,
    PS_IDLE   = 3'd1,
    PS_SAVE   = 3'd2,
    PS_OFF    = 3'd3,
    PS_STAB   = 3'd4,
    PS_RST    = 3'd5
  } pwrState_e;

  localparam logic [2:0] MODE_IDLE = 3'b000;
  localparam logic [2:0] MODE_SAVE = 3'b011;
  localparam logic [2:0] MODE_OFF  = 3'b100;

  localparam logic [1:0] ADDR_CTL  = 2'd0;
  localparam logic [1:0] ADDR_MASK = 2'd1;
  localparam logic [1:0] ADDR_DLY  = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic loadStab;
    logic decStab;
    logic clrRegs;
    logic countHold;
  } ctlStrobes_t;

  // status from datapath to control
  typedef struct packed {
    logic       sleepEn;
    logic [2:0] mode;
    logic       winOpen;
    logic       wakeOk;
    logic       stabLast;
    logic       stabCfgZero;
  } dpStatus_t;

endpackage

// File: rtl/pwrCtlFsm.sv
module pwrCtlFsm
  import pwrCtlPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sleepReq,
  input  logic        chargerDet,
  input  dpStatus_t   status,
  output pwrState_e   state,
  output ctlStrobes_t strobes
);

  pwrState_e nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      PS_ACTIVE: begin
        if (sleepReq && status.sleepEn) begin
          if (status.mode == MODE_IDLE)                        nextState = PS_IDLE;
          else if (status.mode == MODE_SAVE)                   nextState = PS_SAVE;
          else if (status.mode == MODE_OFF && status.winOpen)  nextState = PS_OFF;
        end
      end
      PS_IDLE: if (status.wakeOk) nextState = PS_ACTIVE;
      PS_SAVE: begin
        if (status.wakeOk) nextState = status.stabCfgZero ? PS_ACTIVE : PS_STAB;
      end
      PS_STAB: if (status.stabLast) nextState = PS_ACTIVE;
      PS_OFF:  if (chargerDet) nextState = PS_RST;
      PS_RST:  nextState = PS_ACTIVE;
      default: nextState = PS_ACTIVE;
    endcase
  end

  always_comb begin
    strobes.loadStab  = (state == PS_SAVE) && status.wakeOk && !status.stabCfgZero;
    strobes.decStab   = (state == PS_STAB);
    strobes.clrRegs   = (state == PS_RST);
    strobes.countHold = (state == PS_IDLE) || (state == PS_SAVE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PS_ACTIVE;
    else       state <= nextState;
  end

endmodule

// File: rtl/pwrCtlData.sv
module pwrCtlData
  import pwrCtlPkg::*;
#(
  parameter int NUM_PERIPH = 4,
  parameter int DLY_W      = 16,
  parameter int HOLD_CYC   = 4,
  parameter int WIN_CYC    = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWe,
  input  logic [1:0]            cfgAddr,
  input  logic [DLY_W-1:0]      cfgWdata,
  input  logic                  wakeLvl,
  input  ctlStrobes_t           strobes,
  output dpStatus_t             status,
  output logic                  wdOn,
  output logic [NUM_PERIPH-1:0] mask
);

  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam int WW = $clog2(WIN_CYC + 1) + 1;
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYC - 1);
  localparam logic [HW-1:0] HOLD_MAX  = HW'(HOLD_CYC);
  localparam logic [WW-1:0] WIN_MAX   = WW'(WIN_CYC);

  logic [4:0]       ctlReg;
  logic [DLY_W-1:0] dlyReg;
  logic [DLY_W-1:0] stabCnt;
  logic [HW-1:0]    holdCnt;
  logic [WW-1:0]    sinceWr;
  logic             ctlWrite;

  assign ctlWrite = cfgWe && (cfgAddr == ADDR_CTL);

  // configuration registers and power-off arming window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlReg  <= '0;
      mask    <= '0;
      dlyReg  <= '0;
      sinceWr <= WIN_MAX;
    end else if (strobes.clrRegs) begin
      ctlReg  <= '0;
      mask    <= '0;
      sinceWr <= WIN_MAX;
    end else begin
      if (cfgWe) begin
        case (cfgAddr)
          ADDR_CTL:  ctlReg <= cfgWdata[4:0];
          ADDR_MASK: mask   <= cfgWdata[NUM_PERIPH-1:0];
          ADDR_DLY:  dlyReg <= cfgWdata;
          default:   ;
        endcase
      end
      if (ctlWrite)                sinceWr <= '0;
      else if (sinceWr < WIN_MAX)  sinceWr <= sinceWr + 1'b1;
    end
  end

  // stabilisation counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 stabCnt <= '0;
    else if (strobes.loadStab) stabCnt <= dlyReg;
    else if (strobes.decStab)  stabCnt <= stabCnt - 1'b1;
  end

  // wake-level hold qualification
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdCnt <= '0;
    else if (strobes.countHold && wakeLvl) begin
      if (holdCnt < HOLD_MAX) holdCnt <= holdCnt + 1'b1;
    end else holdCnt <= '0;
  end

  always_comb begin
    status.sleepEn     = ctlReg[0];
    status.mode        = ctlReg[3:1];
    status.winOpen     = sinceWr < WIN_MAX;
    status.wakeOk      = strobes.countHold && wakeLvl && (holdCnt >= HOLD_LAST);
    status.stabLast    = stabCnt <= DLY_W'(1);
    status.stabCfgZero = (dlyReg == '0);
  end

  assign wdOn = ctlReg[4];

endmodule

// File: rtl/pwrPeriphGate.sv
module pwrPeriphGate
  import pwrCtlPkg::*;
#(
  parameter int NUM_PERIPH = 4,
  parameter int PER_DW     = 8,
  localparam int SEL_W     = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1
) (
  input  pwrState_e                    state,
  input  logic [NUM_PERIPH-1:0]        mask,
  input  logic [SEL_W-1:0]             perSel,
  input  logic                         perWr,
  input  logic [NUM_PERIPH*PER_DW-1:0] perRdIn,
  output logic [PER_DW-1:0]            perRdOut,
  output logic [NUM_PERIPH-1:0]        perWrEn,
  output logic [NUM_PERIPH-1:0]        periphClkEn
);

  logic clkAllowed;
  logic [PER_DW-1:0] rdArr [NUM_PERIPH];

  assign clkAllowed = (state == PS_ACTIVE) || (state == PS_IDLE);

  for (genvar i = 0; i < NUM_PERIPH; i++) begin : gPer
    assign periphClkEn[i] = clkAllowed && !mask[i];
    assign perWrEn[i]     = perWr && (perSel == SEL_W'(i)) && !mask[i];
    assign rdArr[i]       = mask[i] ? '0 : perRdIn[i*PER_DW +: PER_DW];
  end

  assign perRdOut = rdArr[perSel];

endmodule

// File: rtl/pwrSleepCtl.sv
module pwrSleepCtl
  import pwrCtlPkg::*;
#(
  parameter int NUM_PERIPH = 4,
  parameter int PER_DW     = 8,
  parameter int DLY_W      = 16,
  parameter int HOLD_CYC   = 4,
  parameter int WIN_CYC    = 4,
  localparam int SEL_W     = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cfgWe,
  input  logic [1:0]                   cfgAddr,
  input  logic [DLY_W-1:0]             cfgWdata,
  input  logic                         sleepReq,
  input  logic                         wakeLvl,
  input  logic                         chargerDet,
  input  logic [SEL_W-1:0]             perSel,
  input  logic                         perWr,
  input  logic [NUM_PERIPH*PER_DW-1:0] perRdIn,
  output logic [PER_DW-1:0]            perRdOut,
  output logic [NUM_PERIPH-1:0]        perWrEn,
  output logic [NUM_PERIPH-1:0]        periphClkEn,
  output logic                         cpuClkEn,
  output logic                         regOff,
  output logic                         sysRstReq,
  output logic                         wdRunEn,
  output logic [2:0]                   pwrState
);

  pwrState_e             state;
  ctlStrobes_t           strobes;
  dpStatus_t             status;
  logic                  wdOn;
  logic [NUM_PERIPH-1:0] mask;

  pwrCtlFsm uFsm (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .chargerDet(chargerDet),
    .status(status), .state(state), .strobes(strobes)
  );

  pwrCtlData #(
    .NUM_PERIPH(NUM_PERIPH), .DLY_W(DLY_W), .HOLD_CYC(HOLD_CYC), .WIN_CYC(WIN_CYC)
  ) uData (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .wakeLvl(wakeLvl), .strobes(strobes), .status(status), .wdOn(wdOn), .mask(mask)
  );

  pwrPeriphGate #(.NUM_PERIPH(NUM_PERIPH), .PER_DW(PER_DW)) uGate (
    .state(state), .mask(mask), .perSel(perSel), .perWr(perWr), .perRdIn(perRdIn),
    .perRdOut(perRdOut), .perWrEn(perWrEn), .periphClkEn(periphClkEn)
  );

  assign cpuClkEn  = (state == PS_ACTIVE);
  assign regOff    = (state == PS_OFF);
  assign sysRstReq = (state == PS_RST);
  assign wdRunEn   = wdOn && (state != PS_OFF);
  assign pwrState  = state;

endmodule

// File: rtl/pwrSleepCtl_chk.sv
module pwrSleepCtl_chk #(
  parameter int NUM_PERIPH = 4,
  parameter int PER_DW     = 8,
  parameter int DLY_W      = 16,
  parameter int WIN_CYC    = 4,
  localparam int SEL_W     = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  cfgWe,
  input logic [1:0]            cfgAddr,
  input logic                  chargerDet,
  input logic [SEL_W-1:0]      perSel,
  input logic [NUM_PERIPH-1:0] perWrEn,
  input logic [NUM_PERIPH-1:0] periphClkEn,
  input logic                  cpuClkEn,
  input logic                  regOff,
  input logic                  sysRstReq,
  input logic                  wdRunEn,
  input logic [2:0]            pwrState
);

  localparam int CW = $clog2(WIN_CYC + 2) + 1;
  localparam logic [CW-1:0] CMAX = CW'(WIN_CYC + 1);
  logic [CW-1:0] sinceCtl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceCtl <= CMAX;
    else if (cfgWe && cfgAddr == 2'd0) sinceCtl <= '0;
    else if (sinceCtl < CMAX) sinceCtl <= sinceCtl + 1'b1;
  end

  // R2
  poff_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(regOff) |-> ($past(sinceCtl) < CW'(WIN_CYC)));

  // R3
  poff_clocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    regOff |-> (periphClkEn == '0 && !cpuClkEn));

  // R4
  poff_exit_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regOff && chargerDet) |=> (sysRstReq && !regOff));

  // R5
  wd_off_in_poff_chk: assert property (@(posedge clk) disable iff (!rstN)
    regOff |-> !wdRunEn);

  // R6
  stab_cpu_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 3'd4) |-> !cpuClkEn);

  // R8
  gated_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuClkEn && !periphClkEn[perSel]) |-> (perWrEn[perSel] == 1'b0));

endmodule

bind pwrSleepCtl pwrSleepCtl_chk #(
  .NUM_PERIPH(NUM_PERIPH), .PER_DW(PER_DW), .DLY_W(DLY_W), .WIN_CYC(WIN_CYC)
) uChk (.*);

// File: tb/sim_pwrSleepCtl.sv
`timescale 1ns/100ps
module sim_pwrSleepCtl;

  localparam int NP = 4;
  localparam int DW = 8;
  localparam int HOLD = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [1:0] cfgAddr = '0;
  logic [15:0] cfgWdata = '0;
  logic sleepReq = 1'b0, wakeLvl = 1'b0, chargerDet = 1'b0;
  logic [1:0] perSel = '0;
  logic perWr = 1'b0;
  logic [NP*DW-1:0] perRdIn = 32'hD4C3B2A1;
  logic [DW-1:0] perRdOut;
  logic [NP-1:0] perWrEn, periphClkEn;
  logic cpuClkEn, regOff, sysRstReq, wdRunEn;
  logic [2:0] pwrState;

  int nRun = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  pwrSleepCtl #(.NUM_PERIPH(NP), .PER_DW(DW), .DLY_W(16), .HOLD_CYC(HOLD), .WIN_CYC(4)) u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .sleepReq(sleepReq), .wakeLvl(wakeLvl), .chargerDet(chargerDet), .perSel(perSel),
    .perWr(perWr), .perRdIn(perRdIn), .perRdOut(perRdOut), .perWrEn(perWrEn),
    .periphClkEn(periphClkEn), .cpuClkEn(cpuClkEn), .regOff(regOff),
    .sysRstReq(sysRstReq), .wdRunEn(wdRunEn), .pwrState(pwrState)
  );

  // {ctl[4:0], gap[3:0], expected state[2:0]}
  localparam logic [11:0] VECS [8] = '{
    {5'h11, 4'd1, 3'd1},  // R1 idle
    {5'h17, 4'd2, 3'd2},  // R1 power-save
    {5'h19, 4'd4, 3'd3},  // R2 last cycle of window
    {5'h19, 4'd5, 3'd0},  // R2 one cycle late
    {5'h10, 4'd1, 3'd0},  // R11 enable clear
    {5'h1B, 4'd1, 3'd0},  // R11 reserved mode 101
    {5'h19, 4'd1, 3'd3},  // R2 first cycle of window
    {5'h15, 4'd1, 3'd0}   // R11 reserved mode 010
  };

  task automatic chk(input string req, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [1:0] a, input logic [15:0] d);
    cfgAddr = a; cfgWdata = d; cfgWe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // request sampled `gap` edges after the control-word write edge
  task automatic sleepAfter(input logic [4:0] ctl, input int gap);
    cfgWrite(2'd0, {11'd0, ctl});
    repeat (gap - 1) @(negedge clk);
    sleepReq = 1'b1;
    @(negedge clk);
    sleepReq = 1'b0;
  endtask

  task automatic wakeHold(input int n);
    wakeLvl = 1'b1;
    repeat (n) @(negedge clk);
    wakeLvl = 1'b0;
  endtask

  task automatic chargerExit();
    chargerDet = 1'b1;
    @(negedge clk);
    chargerDet = 1'b0;
    chk("R4 state", pwrState, 5);
    chk("R4 sysRstReq", sysRstReq, 1);
    @(negedge clk);
    chk("R4 back active", pwrState, 0);
    chk("R4 sysRstReq low", sysRstReq, 0);
    chk("R4 ctl cleared", wdRunEn, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R12 reset state
    chk("R12 state", pwrState, 0);
    chk("R12 cpuClkEn", cpuClkEn, 1);
    chk("R12 regOff", regOff, 0);
    chk("R12 sysRstReq", sysRstReq, 0);
    chk("R12 wdRunEn", wdRunEn, 0);
    chk("R12 periphClkEn", periphClkEn, 4'hF);

    cfgWrite(2'd2, 16'd0);
    for (int i = 0; i < 8; i++) begin
      logic [4:0] ctl;
      int gap, expSt;
      ctl = VECS[i][11:7];
      gap = int'(VECS[i][6:3]);
      expSt = int'(VECS[i][2:0]);
      sleepAfter(ctl, gap);
      chk("R1/R2/R11 vector state", pwrState, expSt);
      chk("R3 regOff", regOff, (expSt == 3) ? 1 : 0);
      chk("R5 wdRunEn", wdRunEn, (expSt == 3) ? 0 : 1);
      if (expSt == 1 || expSt == 2) begin
        wakeHold(HOLD);
        chk("R7 wake to active", pwrState, 0);
      end else if (expSt == 3) begin
        chargerExit();
      end
    end

    // R3 wake level ignored in power-off
    sleepAfter(5'h19, 1);
    wakeHold(HOLD + 3);
    chk("R3 wakeLvl ignored", pwrState, 3);
    chk("R3 cpuClkEn", cpuClkEn, 0);
    chk("R10 clocks off in power-off", periphClkEn, 0);
    chargerExit();

    // R7 short pulse, then R6 delay of 5
    cfgWrite(2'd2, 16'd5);
    sleepAfter(5'h17, 1);
    chk("R10 clocks off in power-save", periphClkEn, 0);
    wakeHold(HOLD - 1);
    @(negedge clk);
    chk("R7 short pulse ignored", pwrState, 2);
    wakeHold(HOLD);
    chk("R6 stabilising", pwrState, 4);
    chk("R6 cpu clock off", cpuClkEn, 0);
    chk("R10 clocks off while stabilising", periphClkEn, 0);
    repeat (4) @(negedge clk);
    chk("R6 still stabilising at D-1", pwrState, 4);
    @(negedge clk);
    chk("R6 active after D", pwrState, 0);

    // R6 zero delay
    cfgWrite(2'd2, 16'd0);
    sleepAfter(5'h17, 1);
    wakeHold(HOLD);
    chk("R6 zero delay immediate", pwrState, 0);

    // R7 idle: short pulse ignored, full hold wakes
    sleepAfter(5'h11, 1);
    wakeHold(HOLD - 1);
    @(negedge clk);
    chk("R7 idle short pulse", pwrState, 1);
    chk("R5 wdRunEn in idle", wdRunEn, 1);
    wakeHold(HOLD);
    chk("R7 idle wake", pwrState, 0);

    // R8 peripheral gating
    cfgWrite(2'd1, 16'h0002);
    chk("R8 clock mask active", periphClkEn, 4'hD);
    perSel = 2'd1; perWr = 1'b1;
    #1;
    chk("R8 masked read zero", perRdOut, 0);
    chk("R8 masked write dropped", perWrEn, 0);
    perSel = 2'd2;
    #1;
    chk("R8 unmasked read", perRdOut, 8'hC3);
    chk("R8 unmasked write", perWrEn, 4'h4);
    perWr = 1'b0;
    sleepAfter(5'h11, 1);
    chk("R8 clock mask in idle", periphClkEn, 4'hD);
    wakeHold(HOLD);

    // R9 restore
    cfgWrite(2'd1, 16'h0000);
    perSel = 2'd1; perWr = 1'b1;
    #1;
    chk("R9 clock restored", periphClkEn, 4'hF);
    chk("R9 read restored", perRdOut, 8'hB2);
    chk("R9 write restored", perWrEn, 4'h2);
    perWr = 1'b0;
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule